// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds sixteen 32-bit general registers for a processor core. The low eight logical registers have two physical copies, called bank 0 and bank 1. The high eight logical registers have a single copy that both banks share. A small status register decides which copy of the low eight the normal ports reach. It holds a privilege bit, a bank-select bit, a block bit and a 4-bit interrupt mask.

The normal ports are two combinational read ports and one write port. In privileged mode the bank-select bit picks the visible copy. In user mode bank 0 is always the visible copy. A separate alternate port has a 3-bit index and reaches the copy that is currently hidden. It serves instructions that move data between the banks. It works only in privileged mode; in user mode any use of it is refused and flagged. Logical register 0 of the visible bank is also driven on a dedicated output, so it can serve as an index operand.

Top module: `banked_gpr_file`

## Requirements
- R1: Logical registers 8 to 15 have one shared copy: a value written to one of them is read back unchanged under every privilege/bank setting.
- R2: With privilege 1 and bank bit 1, the normal ports reach bank 1 for registers 0 to 7, and the alternate port (index 0 to 7) reaches bank 0.
- R3: With privilege 1 and bank bit 0, the normal ports reach bank 0 for registers 0 to 7, and the alternate port reaches bank 1.
- R4: With privilege 0, the normal ports reach bank 0 for registers 0 to 7 whatever the bank bit is, and bank 1 cannot be reached.
- R5: Any alternate-port read or write in user mode is refused. `alt_illegal` is 1 in the same cycle, `alt_rd_data` reads as zero, and the write leaves both banks unchanged.
- R6: A synchronous reset sets privilege to 1, bank to 1, block to 1 and interrupt mask to 4'hF. Register contents are not defined by reset.
- R7: When a read addresses the register that the same cycle writes, it returns the new value. This holds for the normal ports and for the alternate port.
- R8: When `st_we` is 1, all four status fields load on that clock edge. The new steering applies to accesses in the very next cycle.
- R9: `idx_r0` always equals the value that a normal read of logical register 0 returns in the same cycle.
- R10: In privileged mode, a normal write and an alternate write in the same cycle both complete, even when they carry the same register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status bits |
| st_we | input | 1 | Load the status fields |
| st_priv_in | input | 1 | New privilege bit (1 = privileged) |
| st_bank_in | input | 1 | New bank-select bit |
| st_blk_in | input | 1 | New block bit |
| st_imask_in | input | 4 | New interrupt mask |
| st_priv | output | 1 | Current privilege bit |
| st_bank | output | 1 | Current bank-select bit |
| st_blk | output | 1 | Current block bit |
| st_imask | output | 4 | Current interrupt mask |
| rd_a_addr | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 4 | Normal write logical index |
| wr_data | input | 32 | Normal write data |
| alt_rd_en | input | 1 | Alternate-bank read request |
| alt_rd_addr | input | 3 | Alternate-bank read index |
| alt_rd_data | output | 32 | Alternate-bank read data (zero when refused) |
| alt_wr_en | input | 1 | Alternate-bank write request |
| alt_wr_addr | input | 3 | Alternate-bank write index |
| alt_wr_data | input | 32 | Alternate-bank write data |
| alt_illegal | output | 1 | Alternate access refused in user mode |
| idx_r0 | output | 32 | Register 0 of the visible bank |

## Verification
The read data, `idx_r0` and `alt_illegal` are combinational, so they are due in the same cycle that the address or request is presented. The bench drives each access just after a falling edge and samples one time unit later, well before the next rising edge. A write or a status load takes effect at the next rising edge. Every later access is therefore driven after the following falling edge, and its results are compared against a bench model of the three physical groups (bank 0, bank 1, shared). The bench sweeps all four privilege/bank combinations and writes every register in each. It then reads every register back across all settings, so each value written under one setting is also checked under the others.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int IMASK_W = 4;

    typedef struct packed {
        logic               priv;
        logic               bank;
        logic               blk;
        logic [IMASK_W-1:0] imask;
    } gpr_status_t;

    localparam gpr_status_t STATUS_RST = '{priv: 1'b1, bank: 1'b1, blk: 1'b1, imask: '1};

    typedef enum logic { BANK0 = 1'b0, BANK1 = 1'b1 } gpr_bank_e;

    function automatic gpr_bank_e visible_bank(input gpr_status_t s);
        return (s.priv && s.bank) ? BANK1 : BANK0;
    endfunction

    function automatic gpr_bank_e hidden_bank(input gpr_status_t s);
        return (visible_bank(s) == BANK1) ? BANK0 : BANK1;
    endfunction

endpackage

// File: rtl/gpr_status_reg.sv
module gpr_status_reg
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld,
    input  gpr_status_t ld_val,
    output gpr_status_t q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= STATUS_RST;
        else if (ld) q <= ld_val;
    end

    a_r6_reset_values: assert property (@(posedge clk)
        $past(rst) |-> (q.priv && q.bank && q.blk && (q.imask == '1)));

    a_r8_load_lands: assert property (@(posedge clk) disable iff (rst)
        (ld && !rst) |=> (q == $past(ld_val)));

endmodule

// File: rtl/gpr_steer.sv
module gpr_steer
    import gpr_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int NBANKED = 8,
    parameter int NRD     = 2
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  gpr_status_t                                st,
    input  logic [NRD-1:0][$clog2(NREG)-1:0]           rd_addr,
    input  logic [$clog2(NREG)-1:0]                    wr_addr,
    input  logic [$clog2(NBANKED)-1:0]                 alt_rd_addr,
    input  logic [$clog2(NBANKED)-1:0]                 alt_wr_addr,
    output logic [NRD-1:0][$clog2(NREG+NBANKED)-1:0]   rd_phys,
    output logic [$clog2(NREG+NBANKED)-1:0]            wr_phys,
    output logic [$clog2(NREG+NBANKED)-1:0]            alt_rd_phys,
    output logic [$clog2(NREG+NBANKED)-1:0]            alt_wr_phys,
    output logic [$clog2(NREG+NBANKED)-1:0]            idx_phys,
    output logic                                       alt_ok
);

    localparam int AW  = $clog2(NREG);
    localparam int BAW = $clog2(NBANKED);
    localparam int PAW = $clog2(NREG + NBANKED);

    gpr_bank_e vis, hid;

    assign vis    = visible_bank(st);
    assign hid    = hidden_bank(st);
    assign alt_ok = st.priv;

    // Physical layout: [0, NBANKED) bank 0, [NBANKED, 2*NBANKED) bank 1,
    // [2*NBANKED, NREG+NBANKED) shared registers.
    function automatic logic [PAW-1:0] map_logical(input logic [AW-1:0] a, input gpr_bank_e b);
        if (a < AW'(NBANKED))
            return PAW'((b == BANK1) ? NBANKED : 0) + PAW'(a);
        else
            return PAW'(NBANKED) + PAW'(a);
    endfunction

    function automatic logic [PAW-1:0] map_hidden(input logic [BAW-1:0] a, input gpr_bank_e b);
        return PAW'((b == BANK1) ? NBANKED : 0) + PAW'(a);
    endfunction

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_phys[p] = map_logical(rd_addr[p], vis);
    end

    assign wr_phys     = map_logical(wr_addr, vis);
    assign idx_phys    = map_logical('0, vis);
    assign alt_rd_phys = map_hidden(alt_rd_addr, hid);
    assign alt_wr_phys = map_hidden(alt_wr_addr, hid);

    a_r4_user_stays_bank0: assert property (@(posedge clk) disable iff (rst)
        (!st.priv && (rd_addr[0] < AW'(NBANKED))) |-> (rd_phys[0] < PAW'(NBANKED)));

    a_r2_alt_hits_bank0: assert property (@(posedge clk) disable iff (rst)
        (st.priv && st.bank) |-> (alt_rd_phys < PAW'(NBANKED)));

    a_r3_alt_hits_bank1: assert property (@(posedge clk) disable iff (rst)
        (st.priv && !st.bank) |-> ((alt_wr_phys >= PAW'(NBANKED)) && (alt_wr_phys < PAW'(2*NBANKED))));

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 24,
    parameter int NRP    = 4
) (
    input  logic                                    clk,
    input  logic                                    we_p,
    input  logic [$clog2(NPHYS)-1:0]                wa_p,
    input  logic [DATA_W-1:0]                       wd_p,
    input  logic                                    we_s,
    input  logic [$clog2(NPHYS)-1:0]                wa_s,
    input  logic [DATA_W-1:0]                       wd_s,
    input  logic [NRP-1:0][$clog2(NPHYS)-1:0]       ra,
    output logic [NRP-1:0][DATA_W-1:0]              rd
);

    logic [DATA_W-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (we_s) mem[wa_s] <= wd_s;
        if (we_p) mem[wa_p] <= wd_p;
    end

    // Same-cycle forwarding; the primary port takes precedence.
    for (genvar p = 0; p < NRP; p++) begin : g_rp
        assign rd[p] = (we_p && (wa_p == ra[p])) ? wd_p :
                       (we_s && (wa_s == ra[p])) ? wd_s : mem[ra[p]];
    end

endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
    import gpr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NREG    = 16,
    parameter int NBANKED = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        st_we,
    input  logic                        st_priv_in,
    input  logic                        st_bank_in,
    input  logic                        st_blk_in,
    input  logic [3:0]                  st_imask_in,
    output logic                        st_priv,
    output logic                        st_bank,
    output logic                        st_blk,
    output logic [3:0]                  st_imask,
    input  logic [$clog2(NREG)-1:0]     rd_a_addr,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [$clog2(NREG)-1:0]     rd_b_addr,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NREG)-1:0]     wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        alt_rd_en,
    input  logic [$clog2(NBANKED)-1:0]  alt_rd_addr,
    output logic [DATA_W-1:0]           alt_rd_data,
    input  logic                        alt_wr_en,
    input  logic [$clog2(NBANKED)-1:0]  alt_wr_addr,
    input  logic [DATA_W-1:0]           alt_wr_data,
    output logic                        alt_illegal,
    output logic [DATA_W-1:0]           idx_r0
);

    localparam int AW    = $clog2(NREG);
    localparam int NPHYS = NREG + NBANKED;
    localparam int PAW   = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NRP   = NRD + 2;

    gpr_status_t st_q, st_d;

    assign st_d = '{priv: st_priv_in, bank: st_bank_in, blk: st_blk_in, imask: st_imask_in};

    gpr_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .ld     (st_we),
        .ld_val (st_d),
        .q      (st_q)
    );

    assign st_priv  = st_q.priv;
    assign st_bank  = st_q.bank;
    assign st_blk   = st_q.blk;
    assign st_imask = st_q.imask;

    logic [NRD-1:0][AW-1:0]  rd_addr;
    logic [NRD-1:0][PAW-1:0] rd_phys;
    logic [PAW-1:0]          wr_phys, alt_rd_phys, alt_wr_phys, idx_phys;
    logic                    alt_ok;

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    gpr_steer #(.NREG(NREG), .NBANKED(NBANKED), .NRD(NRD)) u_steer (
        .clk         (clk),
        .rst         (rst),
        .st          (st_q),
        .rd_addr     (rd_addr),
        .wr_addr     (wr_addr),
        .alt_rd_addr (alt_rd_addr),
        .alt_wr_addr (alt_wr_addr),
        .rd_phys     (rd_phys),
        .wr_phys     (wr_phys),
        .alt_rd_phys (alt_rd_phys),
        .alt_wr_phys (alt_wr_phys),
        .idx_phys    (idx_phys),
        .alt_ok      (alt_ok)
    );

    logic [NRP-1:0][PAW-1:0]    ra;
    logic [NRP-1:0][DATA_W-1:0] rdata;

    assign ra[0] = rd_phys[0];
    assign ra[1] = rd_phys[1];
    assign ra[2] = alt_rd_phys;
    assign ra[3] = idx_phys;

    gpr_storage #(.DATA_W(DATA_W), .NPHYS(NPHYS), .NRP(NRP)) u_store (
        .clk  (clk),
        .we_p (wr_en),
        .wa_p (wr_phys),
        .wd_p (wr_data),
        .we_s (alt_wr_en && alt_ok),
        .wa_s (alt_wr_phys),
        .wd_s (alt_wr_data),
        .ra   (ra),
        .rd   (rdata)
    );

    assign rd_a_data   = rdata[0];
    assign rd_b_data   = rdata[1];
    assign alt_rd_data = (alt_rd_en && alt_ok) ? rdata[2] : '0;
    assign idx_r0      = rdata[3];
    assign alt_illegal = (alt_rd_en || alt_wr_en) && !alt_ok;

    a_r5_refused_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (alt_rd_en && !st_priv) |-> (alt_illegal && (alt_rd_data == '0)));

    a_r7_forward_new_value: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd_a_addr == wr_addr)) |-> (rd_a_data == wr_data));

    a_r9_index_matches_r0: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (idx_r0 == rd_b_data));

    a_r1_shared_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !st_we && (rd_a_addr >= AW'(NBANKED))) |=> (rd_a_addr != $past(rd_a_addr)) || $stable(rd_a_data));

endmodule

// File: tb/sim_banked_gpr_file.sv
module sim_banked_gpr_file;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_we, st_priv_in, st_bank_in, st_blk_in;
    logic [3:0]  st_imask_in;
    logic        st_priv, st_bank, st_blk;
    logic [3:0]  st_imask;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, alt_rd_en, alt_wr_en, alt_illegal;
    logic [2:0]  alt_rd_addr, alt_wr_addr;
    logic [31:0] alt_rd_data, alt_wr_data, idx_r0;

    always #(CLK_P/2) clk = ~clk;

    banked_gpr_file u0 (.*);

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_sh [8];
    logic        m_priv, m_bank;

    function automatic logic [31:0] exp_norm(input int a);
        if (a >= 8) return m_sh[a-8];
        return (m_priv && m_bank) ? m_b1[a] : m_b0[a];
    endfunction

    function automatic logic [31:0] exp_alt(input int a);
        return (m_priv && m_bank) ? m_b0[a] : m_b1[a];
    endfunction

    function automatic string tag_for(input int a);
        if (a >= 8) return "R1";
        if (!m_priv) return "R4";
        return m_bank ? "R2" : "R3";
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic quiet();
        st_we = 0; wr_en = 0; alt_rd_en = 0; alt_wr_en = 0;
    endtask

    task automatic set_status(input logic p, input logic b);
        @(negedge clk);
        quiet();
        st_we = 1; st_priv_in = p; st_bank_in = b; st_blk_in = 0; st_imask_in = {p, b, 2'b01};
        @(negedge clk);
        quiet();
        m_priv = p; m_bank = b;
        #1;
        chk("R8", "status priv", {31'd0, st_priv}, {31'd0, p});
        chk("R8", "status bank", {31'd0, st_bank}, {31'd0, b});
        chk("R8", "status mask", {28'd0, st_imask}, {28'd0, p, b, 2'b01});
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        quiet();
        wr_en = 1; wr_addr = 4'(a); wr_data = d; rd_a_addr = 4'(a);
        #1;
        chk("R7", "normal forward", rd_a_data, d);
        if (a >= 8) m_sh[a-8] = d;
        else if (m_priv && m_bank) m_b1[a] = d;
        else m_b0[a] = d;
    endtask

    task automatic awr(input int a, input logic [31:0] d);
        @(negedge clk);
        quiet();
        alt_wr_en = 1; alt_wr_addr = 3'(a); alt_wr_data = d;
        alt_rd_en = 1; alt_rd_addr = 3'(a);
        #1;
        if (!m_priv) begin
            chk("R5", "illegal flag on write", {31'd0, alt_illegal}, 32'd1);
            chk("R5", "refused read data", alt_rd_data, 32'd0);
        end else begin
            chk("R7", "alt forward", alt_rd_data, d);
            chk("R5", "no flag when privileged", {31'd0, alt_illegal}, 32'd0);
            if (m_bank) m_b0[a] = d; else m_b1[a] = d;
        end
    endtask

    task automatic rd_chk(input int a);
        @(negedge clk);
        quiet();
        rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
        #1;
        chk(tag_for(a), $sformatf("port A r%0d", a), rd_a_data, exp_norm(a));
        chk(tag_for(15 - a), $sformatf("port B r%0d", 15 - a), rd_b_data, exp_norm(15 - a));
        chk("R9", "index output", idx_r0, exp_norm(0));
    endtask

    task automatic ard_chk(input int a);
        @(negedge clk);
        quiet();
        alt_rd_en = 1; alt_rd_addr = 3'(a);
        #1;
        if (!m_priv) begin
            chk("R5", "user alt read data", alt_rd_data, 32'd0);
            chk("R5", "user alt flag", {31'd0, alt_illegal}, 32'd1);
        end else begin
            chk(m_bank ? "R2" : "R3", $sformatf("alt r%0d", a), alt_rd_data, exp_alt(a));
            chk(m_bank ? "R2" : "R3", "alt flag", {31'd0, alt_illegal}, 32'd0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1; quiet();
        st_priv_in = 0; st_bank_in = 0; st_blk_in = 0; st_imask_in = 0;
        rd_a_addr = 0; rd_b_addr = 0; wr_addr = 0; wr_data = 0;
        alt_rd_addr = 0; alt_wr_addr = 0; alt_wr_data = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R6", "reset priv", {31'd0, st_priv}, 32'd1);
        chk("R6", "reset bank", {31'd0, st_bank}, 32'd1);
        chk("R6", "reset block", {31'd0, st_blk}, 32'd1);
        chk("R6", "reset mask", {28'd0, st_imask}, 32'hF);
        rst = 0;
        m_priv = 1; m_bank = 1;

        // Seed every physical register under privileged settings.
        for (int c = 0; c < 2; c++) begin
            set_status(1'b1, 1'(c));
            for (int i = 0; i < 8; i++) wr(i, {8'h5E, 8'(c), 8'(i), 8'h00});
        end
        for (int i = 8; i < 16; i++) wr(i, {8'h5E, 8'hFF, 8'(i), 8'h00});

        // Sweep all four privilege/bank combinations.
        for (int c = 0; c < 4; c++) begin
            set_status(1'(c >> 1), 1'(c));
            for (int i = 0; i < 16; i++) rd_chk(i);
            for (int i = 0; i < 8; i++) ard_chk(i);
            for (int i = 0; i < 16; i++) wr(i, {8'hC0 | 8'(c), 8'(i), 16'h1234 ^ 16'(i * 77)});
            for (int i = 0; i < 8; i++) awr(i, {8'hA0 | 8'(c), 8'(i), 16'h5A5A ^ 16'(i)});
            for (int i = 0; i < 16; i++) rd_chk(i);
            for (int i = 0; i < 8; i++) ard_chk(i);
        end

        // Values written under user mode are checked again from privileged settings.
        for (int c = 0; c < 2; c++) begin
            set_status(1'b1, 1'(c));
            for (int i = 0; i < 16; i++) rd_chk(i);
            for (int i = 0; i < 8; i++) ard_chk(i);
        end

        // R10: simultaneous normal and alternate writes, same index.
        set_status(1'b1, 1'b1);
        @(negedge clk);
        quiet();
        wr_en = 1; wr_addr = 4'd3; wr_data = 32'hDEAD_0003;
        alt_wr_en = 1; alt_wr_addr = 3'd3; alt_wr_data = 32'hBEEF_0003;
        m_b1[3] = 32'hDEAD_0003; m_b0[3] = 32'hBEEF_0003;
        @(negedge clk);
        quiet();
        rd_a_addr = 4'd3; alt_rd_en = 1; alt_rd_addr = 3'd3;
        #1;
        chk("R10", "normal half of dual write", rd_a_data, 32'hDEAD_0003);
        chk("R10", "alternate half of dual write", alt_rd_data, 32'hBEEF_0003);

        // R8: bank switch applies on the next access, no extra cycle.
        set_status(1'b1, 1'b0);
        rd_chk(3);
        ard_chk(3);

        // R6: reset again from a non-default status.
        set_status(1'b0, 1'b0);
        @(negedge clk);
        quiet();
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk("R6", "re-reset priv", {31'd0, st_priv}, 32'd1);
        chk("R6", "re-reset bank", {31'd0, st_bank}, 32'd1);
        chk("R6", "re-reset block", {31'd0, st_blk}, 32'd1);
        chk("R6", "re-reset mask", {28'd0, st_imask}, 32'hF);
        m_priv = 1; m_bank = 1;
        rd_chk(3);

        summary();
        $finish;
    end

endmodule